// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the arithmetic and logic stage of a small load/store integer core. It is purely combinational. Each cycle it takes a first operand, a second operand that an external shifter has already shifted, the carry bit the shifter produced, the core's present negative/zero/carry/overflow flags, a 4-bit operation code and a request to set flags. It returns the operation's value, an enable that tells the register file whether to write that value, and the flag values the core should hold next.

The operations are add, add-with-carry, subtract, compare, AND, OR, XOR, bit-clear, move, move-complement, test (AND for flags only) and test-equal (XOR for flags only). Add-with-carry takes the incoming carry flag as its carry-in, so two 32-bit operations can form a 64-bit sum. The three flag-only operations always update the flags and never write. Every other operation updates the flags only when asked. The adder can be built as one wide add or as a chain of narrower segments, chosen by a parameter.

Top module: `alu_core`

## Requirements
- R1: Operation codes are ADD=0x0, ADC=0x1, SUB=0x2, CMP=0x3, AND=0x4, ORR=0x5, EOR=0x6, BIC=0x7, MOV=0x8, MVN=0x9, TST=0xA, TEQ=0xB. The flag vectors are ordered {N,Z,C,V} from bit 3 down to bit 0.
- R2: CMP, TST and TEQ drive `wr_en_o` low and always update the flags, whatever `set_flags_i` is. The value they compute still appears on `result_o`.
- R3: ADD, ADC, SUB, AND, ORR, EOR, BIC, MOV and MVN drive `wr_en_o` high. They pass `flags_i` unchanged to `flags_o` unless `set_flags_i` is 1.
- R4: For SUB and CMP the value is A − B. C is 1 exactly when A ≥ B as unsigned numbers (no borrow). V is two's-complement overflow.
- R5: For AND, ORR, EOR, BIC, MOV, MVN, TST and TEQ, an updated C equals `shift_cy_i` and V keeps its value from `flags_i`.
- R6: Whenever the flags update, N is bit 31 of the computed value and Z is 1 exactly when the computed value is zero.
- R7: BIC yields A AND NOT B. For example, 0x02FA62CA with 0x0000FFFF gives 0x02FA0000.
- R8: MVN yields NOT B, and MOV yields B.
- R9: TST ANDs A with B, so with B = 1 the Z flag is 1 exactly when bit 0 of A is 0. TEQ XORs A with B, so Z is 1 exactly when A equals B.
- R10: ADC yields A + B + C, where C is `flags_i[1]`. ADD yields A + B. For both, an updated C is the carry out of bit 31 and V is signed overflow.
- R11: Codes 0xC to 0xF write nothing, give a `result_o` of zero and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a_i | input | 32 | First operand |
| opnd_b_i | input | 32 | Second operand, already shifted |
| shift_cy_i | input | 1 | Carry out of the shifter |
| flags_i | input | 4 | Present flags {N,Z,C,V} |
| op_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Request to update flags |
| result_o | output | 32 | Computed value |
| wr_en_o | output | 1 | Register write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
Two things can happen in the same evaluation. First, a set-flags request can arrive together with a flag-only operation; the bench drives CMP with the request both low and high and expects identical flags and no write in both cases. Second, ADC consumes the incoming C while it produces a new one; the bench feeds the flags from the low-word add straight into the high-word ADC and checks both the 64-bit sum and the new carry.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'h0,
      OP_ADC = 4'h1,
      OP_SUB = 4'h2,
      OP_CMP = 4'h3,
      OP_AND = 4'h4,
      OP_ORR = 4'h5,
      OP_EOR = 4'h6,
      OP_BIC = 4'h7,
      OP_MOV = 4'h8,
      OP_MVN = 4'h9,
      OP_TST = 4'hA,
      OP_TEQ = 4'hB
   } alu_op_e;

   localparam int FLG_N = 3;
   localparam int FLG_Z = 2;
   localparam int FLG_C = 1;
   localparam int FLG_V = 0;

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
   parameter int WIDTH = 32,
   parameter int SEG   = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             inv_b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   localparam int NSEG = (SEG >= WIDTH) ? 1 : WIDTH / SEG;

   logic [WIDTH-1:0] b_eff;
   assign b_eff = inv_b_i ? ~b_i : b_i;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_adder: WIDTH must be at least 2");
      end
      if (SEG < WIDTH && (WIDTH % SEG) != 0) begin : g_bad_seg
         $error("alu_adder: SEG must divide WIDTH");
      end

      if (SEG >= WIDTH) begin : g_flat
         logic [WIDTH:0] full;
         assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
         assign sum_o  = full[WIDTH-1:0];
         assign cout_o = full[WIDTH];
      end else begin : g_chain
         logic [NSEG:0] cy;
         assign cy[0] = cin_i;
         for (genvar s = 0; s < NSEG; s++) begin : g_seg
            logic [SEG:0] part;
            assign part = {1'b0, a_i[s*SEG +: SEG]} + {1'b0, b_eff[s*SEG +: SEG]}
                        + {{SEG{1'b0}}, cy[s]};
            assign sum_o[s*SEG +: SEG] = part[SEG-1:0];
            assign cy[s+1] = part[SEG];
         end
         assign cout_o = cy[NSEG];
      end
   endgenerate

   assign ovf_o = (a_i[WIDTH-1] == b_eff[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  alu_op_e          op_i,
   output logic [WIDTH-1:0] res_o
);
   always_comb begin
      unique case (op_i)
         OP_AND, OP_TST: res_o = a_i & b_i;
         OP_ORR:         res_o = a_i | b_i;
         OP_EOR, OP_TEQ: res_o = a_i ^ b_i;
         OP_BIC:         res_o = a_i & ~b_i;
         OP_MOV:         res_o = b_i;
         OP_MVN:         res_o = ~b_i;
         default:        res_o = '0;
      endcase
   end

   always_comb begin
      if (op_i == OP_BIC) begin
         a_r7_bic_clears : assert ((res_o & b_i) == '0)
            else $error("R7: BIC left a bit set that B masks");
      end
   end

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int WIDTH     = 32,
   parameter int ADDER_SEG = 8
) (
   input  logic [WIDTH-1:0] opnd_a_i,
   input  logic [WIDTH-1:0] opnd_b_i,
   input  logic             shift_cy_i,
   input  logic [3:0]       flags_i,
   input  logic [3:0]       op_i,
   input  logic             set_flags_i,
   output logic [WIDTH-1:0] result_o,
   output logic             wr_en_o,
   output logic [3:0]       flags_o
);
   localparam int MSB = WIDTH - 1;

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic is_arith, is_cmp, is_valid, is_sub, upd;
   assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
   assign is_arith = (op == OP_ADD) || (op == OP_ADC) || is_sub;
   assign is_cmp   = (op == OP_CMP) || (op == OP_TST) || (op == OP_TEQ);
   assign is_valid = (op_i <= 4'hB);
   assign upd      = is_valid && (is_cmp || set_flags_i);

   logic             add_cin;
   logic [WIDTH-1:0] add_sum;
   logic             add_cout, add_ovf;
   assign add_cin = is_sub ? 1'b1 : ((op == OP_ADC) ? flags_i[FLG_C] : 1'b0);

   alu_adder #(.WIDTH(WIDTH), .SEG(ADDER_SEG)) u_adder (
      .a_i     (opnd_a_i),
      .b_i     (opnd_b_i),
      .inv_b_i (is_sub),
      .cin_i   (add_cin),
      .sum_o   (add_sum),
      .cout_o  (add_cout),
      .ovf_o   (add_ovf)
   );

   logic [WIDTH-1:0] log_res;
   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (opnd_a_i),
      .b_i   (opnd_b_i),
      .op_i  (op),
      .res_o (log_res)
   );

   logic [WIDTH-1:0] value;
   logic [3:0]       fresh;
   always_comb begin
      value        = is_arith ? add_sum : log_res;
      fresh[FLG_N] = value[MSB];
      fresh[FLG_Z] = (value == '0);
      fresh[FLG_C] = is_arith ? add_cout : shift_cy_i;
      fresh[FLG_V] = is_arith ? add_ovf  : flags_i[FLG_V];
   end

   assign result_o = is_valid ? value : '0;
   assign wr_en_o  = is_valid && !is_cmp;
   assign flags_o  = upd ? fresh : flags_i;

   always_comb begin
      if (is_cmp) begin
         a_r2_no_write : assert (!wr_en_o)
            else $error("R2: flag-only operation enabled a write");
      end
      if (!is_valid) begin
         a_r11_reserved_idle : assert (!wr_en_o && flags_o == flags_i && result_o == '0)
            else $error("R11: reserved code had an effect");
      end
      if (is_valid && !is_cmp && !set_flags_i) begin
         a_r3_flags_hold : assert (flags_o == flags_i)
            else $error("R3: flags changed without request");
      end
      if (op == OP_CMP) begin
         a_r4_cmp_borrow : assert (flags_o[FLG_C] == (opnd_a_i >= opnd_b_i))
            else $error("R4: compare carry disagrees with unsigned order");
      end
      if (upd && !is_arith) begin
         a_r5_logic_cv : assert (flags_o[FLG_C] == shift_cy_i && flags_o[FLG_V] == flags_i[FLG_V])
            else $error("R5: logic op carry/overflow wrong");
      end
      if (upd) begin
         a_r6_n_msb : assert (flags_o[FLG_N] == result_o[MSB])
            else $error("R6: N differs from result sign");
      end
   end

endmodule

// File: tb/alu_core_bench.sv
module alu_core_bench;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic [31:0] a, b, res;
   logic        cy, sf, we;
   logic [3:0]  fi, op, fo;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   alu_core u_alu_core (
      .opnd_a_i   (a),
      .opnd_b_i   (b),
      .shift_cy_i (cy),
      .flags_i    (fi),
      .op_i       (op),
      .set_flags_i(sf),
      .result_o   (res),
      .wr_en_o    (we),
      .flags_o    (fo)
   );

   task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                        input logic c, input logic [3:0] f, input logic s);
      @(negedge clk);
      op = o; a = x; b = y; cy = c; fi = f; sf = s;
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] exp_r, input logic exp_w,
                      input logic [3:0] exp_f);
      checks++;
      if (res !== exp_r || we !== exp_w || fo !== exp_f) begin
         failures++;
         $display("FAIL %s: got res=%h we=%b flags=%b, expected res=%h we=%b flags=%b",
                  tag, res, we, fo, exp_r, exp_w, exp_f);
      end
   endtask

   task automatic t_idle();
      drive(4'h0, 32'h0, 32'h0, 1'b0, 4'b0000, 1'b0);
      chk("R1 initial add of zeros", 32'h0, 1'b1, 4'b0000);
   endtask

   task automatic t_add();
      drive(4'h0, 32'h7FFFFFFF, 32'h1, 1'b0, 4'b0000, 1'b1);
      chk("R10 add signed overflow", 32'h80000000, 1'b1, 4'b1001);
      drive(4'h0, 32'hFFFFFFFF, 32'h1, 1'b0, 4'b0000, 1'b1);
      chk("R6 R10 add carry to zero", 32'h0, 1'b1, 4'b0110);
      drive(4'h0, 32'h12, 32'h30, 1'b1, 4'b0101, 1'b0);
      chk("R3 add without set keeps flags", 32'h42, 1'b1, 4'b0101);
   endtask

   task automatic t_chain();
      logic [3:0] f_lo;
      drive(4'h0, 32'hFFFFFFFF, 32'h00000001, 1'b0, 4'b0000, 1'b1);
      chk("R10 low word add", 32'h0, 1'b1, 4'b0110);
      f_lo = fo;
      drive(4'h1, 32'h1, 32'h2, 1'b0, f_lo, 1'b1);
      chk("R10 ADC high word with carry in", 32'h4, 1'b1, 4'b0000);
      drive(4'h1, 32'hFFFFFFFF, 32'h0, 1'b0, 4'b0010, 1'b1);
      chk("R10 ADC carry ripple out", 32'h0, 1'b1, 4'b0110);
   endtask

   task automatic t_sub();
      drive(4'h2, 32'h5, 32'h7, 1'b1, 4'b0000, 1'b1);
      chk("R4 sub borrow", 32'hFFFFFFFE, 1'b1, 4'b1000);
      drive(4'h2, 32'h80000000, 32'h1, 1'b0, 4'b0000, 1'b1);
      chk("R4 sub signed overflow", 32'h7FFFFFFF, 1'b1, 4'b0011);
   endtask

   task automatic t_cmp();
      drive(4'h3, 32'h9, 32'h9, 1'b0, 4'b1001, 1'b0);
      chk("R2 R4 cmp equal, no set request", 32'h0, 1'b0, 4'b0110);
      drive(4'h3, 32'h9, 32'h9, 1'b0, 4'b1001, 1'b1);
      chk("R2 cmp equal with set request", 32'h0, 1'b0, 4'b0110);
      drive(4'h3, 32'h3, 32'hFFFFFFF0, 1'b1, 4'b0000, 1'b0);
      chk("R4 cmp unsigned below", 32'h13, 1'b0, 4'b0000);
   endtask

   task automatic t_logic();
      drive(4'h7, 32'h02FA62CA, 32'h0000FFFF, 1'b1, 4'b0001, 1'b1);
      chk("R7 R5 BIC example", 32'h02FA0000, 1'b1, 4'b0011);
      drive(4'h9, 32'h0, 32'h4, 1'b0, 4'b0000, 1'b1);
      chk("R8 MVN of 4", 32'hFFFFFFFB, 1'b1, 4'b1000);
      drive(4'h8, 32'hABCD, 32'h0, 1'b1, 4'b0000, 1'b1);
      chk("R8 R6 MOV zero sets Z", 32'h0, 1'b1, 4'b0110);
      drive(4'h4, 32'hF0F0, 32'hFF00, 1'b0, 4'b1111, 1'b0);
      chk("R3 AND no set", 32'hF000, 1'b1, 4'b1111);
      drive(4'h5, 32'hF0F0, 32'h0F0F, 1'b0, 4'b0000, 1'b0);
      chk("R1 ORR", 32'hFFFF, 1'b1, 4'b0000);
      drive(4'h6, 32'hF0F0, 32'hFF00, 1'b0, 4'b0001, 1'b1);
      chk("R5 EOR keeps V", 32'h0FF0, 1'b1, 4'b0001);
   endtask

   task automatic t_test();
      drive(4'hA, 32'h6, 32'h1, 1'b0, 4'b0001, 1'b0);
      chk("R9 TST even", 32'h0, 1'b0, 4'b0101);
      drive(4'hA, 32'h7, 32'h1, 1'b0, 4'b0001, 1'b0);
      chk("R9 TST odd", 32'h1, 1'b0, 4'b0001);
      drive(4'hB, 32'h5, 32'h5, 1'b1, 4'b0000, 1'b0);
      chk("R9 TEQ equal", 32'h0, 1'b0, 4'b0110);
      drive(4'hB, 32'h5, 32'h4, 1'b1, 4'b0000, 1'b0);
      chk("R9 TEQ differ", 32'h1, 1'b0, 4'b0010);
   endtask

   task automatic t_reserved();
      for (int k = 12; k < 16; k++) begin
         drive(4'(k), 32'h1234, 32'h5678, 1'b1, 4'b1010, 1'b1);
         chk("R11 reserved code inert", 32'h0, 1'b0, 4'b1010);
      end
   endtask

   initial begin
      #100000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      a = '0; b = '0; cy = 1'b0; fi = '0; op = '0; sf = 1'b0;
      repeat (2) @(posedge clk);
      t_idle();
      t_add();
      t_chain();
      t_sub();
      t_cmp();
      t_logic();
      t_test();
      t_reserved();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule